// File: doc/BRIEF.md
# MDIO Management Command Controller

This block runs one management frame at a time toward an external PHY over a two-wire serial management link. A host stages a 16-bit value in a data register, then writes a command word. The command word holds the PHY address, the register address, a write flag, a clock-range select and a busy bit. Setting busy starts a frame. The block generates the management clock from the system clock through a selectable divider. It shifts a 64-bit frame out most significant bit first and clears busy when the last bit period ends.

On a read, the block releases the data pin for the two turnaround bits and the sixteen data bits. It samples the pin on each rising management-clock edge and leaves the sixteen received bits in the data register. The frame sequencer has five states:

- `ST_IDLE`: no frame runs and MDC is held low. `ST_IDLE -> ST_PRE` when busy is set.
- `ST_PRE`: 32 ones. `ST_PRE -> ST_HDR` after bit 31.
- `ST_HDR`: start, opcode, PHY address and register address, 14 bits. `ST_HDR -> ST_TA` after bit 45.
- `ST_TA`: turnaround, 2 bits. `ST_TA -> ST_DAT` after bit 47.
- `ST_DAT`: 16 data bits. `ST_DAT -> ST_IDLE` after bit 63, and this transition clears busy.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the command word and the data register read 0, MDC is low and the data pin is not driven (`mdio_oe` = 0).
- R2: Command word layout (14 bits): bit 0 is busy, bit 1 is the write flag (1 = write, 0 = read), bits [3:2] are the clock-range select, bits [8:4] are the register address and bits [13:9] are the PHY address. Writes go to the command word when `host_sel`=1 and to the data register when `host_sel`=0. Bus bits [13:0] are used for the command word and bits [15:0] for the data register.
- R3: A write frame carries, MSB first, 32 ones, `01`, opcode `01`, the PHY address, the register address, turnaround `10` and the 16 bits of the data register that were present when busy was set. The pin is driven for all 64 bits.
- R4: A read frame carries 32 ones, `01`, opcode `10`, the PHY address and the register address with the pin driven. The pin is released for the turnaround and for all 16 data bits.
- R5: On a read, the pin is sampled on each rising MDC edge of the data phase, MSB first. When busy clears, the data register holds the 16 sampled bits.
- R6: The clock-range select 0, 1, 2 or 3 sets a bit period of `DIV_SEL0`, `DIV_SEL1`, `DIV_SEL2` or `DIV_SEL3` system clocks (defaults 42, 62, 102, 124; each even). MDC is low for the first half of each bit period and high for the second half.
- R7: Busy reads 0 again exactly 64 x divider + 1 cycles after the clock edge that wrote busy = 1. A frame produces exactly 64 MDC rising edges.
- R8: A command-word write while busy is 1 is ignored. The word reads back unchanged and the running frame is unaffected.
- R9: A command-word write with busy = 0 only stores the word. No frame starts and MDC stays low.
- R10: A data-register write while idle is stored and reads back on `data_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 1 = command word, 0 = data register |
| host_wdata | input | 16 | Host write data |
| cmd_rdata | output | 14 | Current command word |
| data_rdata | output | 16 | Current data register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data pin output value |
| mdio_oe | output | 1 | Data pin output enable |
| mdio_i | input | 1 | Data pin input value |

## Verification
The bench builds the block with divider settings 4, 6, 10 and 12 instead of the defaults 42 to 124. A frame therefore lasts a few hundred cycles, and every clock-range select can be exercised with both reads and writes inside a short run. Because the four settings differ from one another, each select produces a distinct, exactly predictable busy latency, so a mis-decoded select shows up as a latency mismatch.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int CMD_W      = 14;
    localparam int DATA_W     = 16;
    localparam int FRAME_LEN  = 64;
    localparam int CNT_W      = $clog2(FRAME_LEN);

    localparam int BIT_BUSY   = 0;
    localparam int BIT_WR     = 1;
    localparam int SEL_LO     = 2;
    localparam int REG_LO     = 4;
    localparam int PHY_LO     = 9;

    localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(31);
    localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(45);
    localparam logic [CNT_W-1:0] TA_LAST    = CNT_W'(47);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_LEN - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DAT
    } seq_state_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_SEL0 = 42,
    parameter int DIV_SEL1 = 62,
    parameter int DIV_SEL2 = 102,
    parameter int DIV_SEL3 = 124
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] div_sel,
    output logic       mdc,
    output logic       rise_stb,
    output logic       end_stb
);
    localparam int MAX01 = (DIV_SEL0 > DIV_SEL1) ? DIV_SEL0 : DIV_SEL1;
    localparam int MAX23 = (DIV_SEL2 > DIV_SEL3) ? DIV_SEL2 : DIV_SEL3;
    localparam int DMAX  = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int CW    = $clog2(DMAX + 1);

    int          div_n;
    logic [CW-1:0] cnt_q, last_v, half_v;

    always_comb begin
        unique case (div_sel)
            2'd0: div_n = DIV_SEL0;
            2'd1: div_n = DIV_SEL1;
            2'd2: div_n = DIV_SEL2;
            2'd3: div_n = DIV_SEL3;
        endcase
        last_v = CW'(div_n - 1);
        half_v = CW'(div_n / 2 - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else begin
            cnt_q <= (cnt_q == last_v) ? '0 : cnt_q + 1'b1;
            if (cnt_q == half_v)
                mdc <= 1'b1;
            else if (cnt_q == last_v)
                mdc <= 1'b0;
        end
    end

    assign rise_stb = run && (cnt_q == half_v);
    assign end_stb  = run && (cnt_q == last_v);

    p_mdc_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);
    p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_v);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_wr,
    input  logic [4:0]        phy_addr,
    input  logic [4:0]        reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_stb,
    input  logic              end_stb,
    input  logic              mdio_i,
    output logic              run,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    seq_state_e             state_q, state_d;
    logic [CNT_W-1:0]       bit_q;
    logic [FRAME_LEN-1:0]   shreg_q;
    logic                   wr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_PRE;
            ST_PRE:  if (end_stb && bit_q == PRE_LAST)   state_d = ST_HDR;
            ST_HDR:  if (end_stb && bit_q == HDR_LAST)   state_d = ST_TA;
            ST_TA:   if (end_stb && bit_q == TA_LAST)    state_d = ST_DAT;
            ST_DAT:  if (end_stb && bit_q == FRAME_LAST) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            shreg_q <= '0;
            wr_q    <= 1'b0;
            rdata   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                bit_q   <= '0;
                wr_q    <= is_wr;
                rdata   <= '0;
                shreg_q <= {32'hFFFF_FFFF, 2'b01,
                            (is_wr ? 2'b01 : 2'b10),
                            phy_addr, reg_addr, 2'b10,
                            (is_wr ? wdata : 16'hFFFF)};
            end else if (state_q != ST_IDLE) begin
                if (end_stb) begin
                    shreg_q <= {shreg_q[FRAME_LEN-2:0], 1'b0};
                    bit_q   <= bit_q + 1'b1;
                end
                if (state_q == ST_DAT && !wr_q && rise_stb)
                    rdata <= {rdata[DATA_W-2:0], mdio_i};
            end
        end
    end

    always_comb begin
        run     = (state_q != ST_IDLE);
        mdio_o  = run & shreg_q[FRAME_LEN-1];
        mdio_oe = run && (wr_q || state_q == ST_PRE || state_q == ST_HDR);
        done    = (state_q == ST_DAT) && end_stb && (bit_q == FRAME_LAST);
    end

    p_release_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_TA || state_q == ST_DAT) && !wr_q) |-> !mdio_oe);
    p_drive_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_q) |-> mdio_oe);
    p_done_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state_q == ST_IDLE));
    p_idle_not_driven_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !mdio_oe);
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              done,
    input  logic [DATA_W-1:0] rdata,
    output logic [CMD_W-1:0]  cmd_q,
    output logic [DATA_W-1:0] data_q
);
    logic busy;
    assign busy = cmd_q[BIT_BUSY];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else begin
            if (done)
                cmd_q[BIT_BUSY] <= 1'b0;
            else if (host_we && host_sel && !busy)
                cmd_q <= host_wdata[CMD_W-1:0];

            if (done && !cmd_q[BIT_WR])
                data_q <= rdata;
            else if (host_we && !host_sel)
                data_q <= host_wdata;
        end
    end

    p_busy_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !cmd_q[BIT_BUSY]);
    p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_we && host_sel && !done) |=> (cmd_q == $past(cmd_q)));
    p_read_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cmd_q[BIT_WR]) |=> (data_q == $past(rdata)));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_SEL0 = 42,
    parameter int DIV_SEL1 = 62,
    parameter int DIV_SEL2 = 102,
    parameter int DIV_SEL3 = 124
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [CMD_W-1:0]  cmd_rdata,
    output logic [DATA_W-1:0] data_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic [CMD_W-1:0]  cmd_q;
    logic [DATA_W-1:0] data_q, rdata;
    logic              run, rise_stb, end_stb, done;

    mdio_host_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .done       (done),
        .rdata      (rdata),
        .cmd_q      (cmd_q),
        .data_q     (data_q)
    );

    mdio_mdc_gen #(
        .DIV_SEL0 (DIV_SEL0),
        .DIV_SEL1 (DIV_SEL1),
        .DIV_SEL2 (DIV_SEL2),
        .DIV_SEL3 (DIV_SEL3)
    ) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div_sel  (cmd_q[SEL_LO+1:SEL_LO]),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .end_stb  (end_stb)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cmd_q[BIT_BUSY]),
        .is_wr    (cmd_q[BIT_WR]),
        .phy_addr (cmd_q[PHY_LO+4:PHY_LO]),
        .reg_addr (cmd_q[REG_LO+4:REG_LO]),
        .wdata    (data_q),
        .rise_stb (rise_stb),
        .end_stb  (end_stb),
        .mdio_i   (mdio_i),
        .run      (run),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rdata    (rdata)
    );

    assign cmd_rdata  = cmd_q;
    assign data_rdata = data_q;

    p_idle_mdc_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_q[BIT_BUSY] && !run) |=> !mdc);
endmodule

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;
    localparam int D0 = 4, D1 = 6, D2 = 10, D3 = 12;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        host_we = 1'b0, host_sel = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [13:0] cmd_rdata;
    logic [15:0] data_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    mdio_mgmt_ctrl #(.DIV_SEL0(D0), .DIV_SEL1(D1), .DIV_SEL2(D2), .DIV_SEL3(D3)) i_mdio_mgmt_ctrl (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .cmd_rdata(cmd_rdata), .data_rdata(data_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: records each bit at the MDC rising edge, returns read data
    logic [15:0] phy_val = '0;
    logic [63:0] cap_o, cap_oe;
    int          k = 0, rises = 0;
    logic        mdc_prev = 1'b0;

    assign mdio_i = (k >= 48 && k < 64) ? phy_val[4'(63 - k)] : 1'b1;

    always @(negedge clk) begin
        if (mdc && !mdc_prev) begin
            if (k < 64) begin
                cap_o[63 - k]  = mdio_o;
                cap_oe[63 - k] = mdio_oe;
            end
            k     = k + 1;
            rises = rises + 1;
        end
        mdc_prev = mdc;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic sel, input logic [15:0] val);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = val;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (!cmd_rdata[0]) break;
        end
    endtask

    function automatic int div_of(input logic [1:0] s);
        return (s == 0) ? D0 : (s == 1) ? D1 : (s == 2) ? D2 : D3;
    endfunction

    // {wr, sel[1:0], phy[4:0], reg[4:0], data[15:0]}
    localparam logic [28:0] VEC [4] = '{
        {1'b1, 2'd0, 5'h01, 5'h00, 16'hA5C3},
        {1'b0, 2'd1, 5'h1F, 5'h11, 16'h3C96},
        {1'b1, 2'd2, 5'h10, 5'h1F, 16'h0001},
        {1'b0, 2'd3, 5'h00, 5'h15, 16'h8000}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cmd", 64'(cmd_rdata), 0);
        chk("R1 data", 64'(data_rdata), 0);
        chk("R1 mdc", 64'(mdc), 0);
        chk("R1 oe", 64'(mdio_oe), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 mdc after release", 64'(mdc), 0);

        // R10: data register write while idle
        host_write(1'b0, 16'h1234);
        chk("R10 data readback", 64'(data_rdata), 64'h1234);

        // R9: command write without busy stores only
        host_write(1'b1, 16'h0A5E);
        repeat (300) @(negedge clk);
        chk("R9 stored", 64'(cmd_rdata), 64'h0A5E);
        chk("R9 no mdc", 64'(rises), 0);

        // Table of frames: R2, R3, R4, R5, R6, R7
        foreach (VEC[v]) begin
            logic wr; logic [1:0] s; logic [4:0] p, r; logic [15:0] d;
            logic [13:0] cmd;
            {wr, s, p, r, d} = VEC[v];
            cmd = {p, r, s, wr, 1'b1};
            if (wr) host_write(1'b0, d); else phy_val = d;
            k = 0; rises = 0; cap_o = '0; cap_oe = '0;
            host_write(1'b1, 16'(cmd));
            wait_idle(lat);
            chk("R7 latency/R6 divider", 64'(lat), 64'(64 * div_of(s) + 1));
            chk("R7 rise count", 64'(rises), 64);
            if (wr) begin
                chk("R3 write frame", cap_o, {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d});
                chk("R3 driven", cap_oe, '1);
            end else begin
                chk("R4 read header", 64'(cap_o[63:18]), 64'({32'hFFFF_FFFF, 2'b01, 2'b10, p, r}));
                chk("R4 released", 64'(cap_oe), {46'h3FFF_FFFF_FFFF, 18'h0});
                chk("R5 read data", 64'(data_rdata), 64'(d));
            end
            chk("R2 busy cleared", 64'(cmd_rdata), 64'({cmd[13:1], 1'b0}));
            repeat (5) @(negedge clk);
            chk("R9 mdc low idle", 64'(mdc), 0);
        end

        // R8: command write while busy is ignored
        phy_val = 16'h5AA5;
        k = 0; rises = 0;
        host_write(1'b1, {2'b00, 5'h03, 5'h02, 2'd0, 1'b0, 1'b1});
        repeat (20) @(negedge clk);
        host_write(1'b1, 16'h3FFF);
        chk("R8 cmd unchanged", 64'(cmd_rdata), 64'({5'h03, 5'h02, 2'd0, 1'b0, 1'b1}));
        wait_idle(lat);
        chk("R8 frame unaffected", 64'(rises), 64);
        chk("R8 read result", 64'(data_rdata), 64'h5AA5);
        chk("R8 cmd after", 64'(cmd_rdata), 64'({5'h03, 5'h02, 2'd0, 1'b0, 1'b0}));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule